// File: doc/BRIEF.md
# Single-Cycle 16-Bit Arithmetic and Logic Unit

This block is the combinational execute stage of a small single-cycle processor. In the same cycle it takes two 16-bit operands, an operation code and a 4-bit shift distance. It returns a 16-bit result together with a sign flag and a zero flag, which the surrounding processor captures when it writes the result back. The unit holds no state, so every output follows its inputs within one clock period.

The block contains four sub-units:

- An adder built from carry-select sections.
- A multiplier that compresses its partial products with rows of 3:2 compressor cells, then resolves them with the same carry-select adder.
- A bitwise logic unit.
- A logarithmic barrel shifter that performs both plain shifts and rotates.

The block never reports a carry. Sums and products that exceed 16 bits wrap silently. Only the sign and zero flags describe the outcome.

Top module: `alu16_core`

## Requirements
- R1: Operation code 0 (add) gives (opa + opb) modulo 2^16. The sum is produced by four 4-bit carry-select sections, each of which computes both possible incoming-carry results.
- R2: Operation code 1 (multiply) gives the low 16 bits of the unsigned product opa * opb.
- R3: Operation codes 2, 3 and 4 give the bitwise AND, OR and XOR of opa and opb respectively.
- R4: Operation code 5 shifts opa left by shamt positions and code 6 shifts it right by shamt positions. Both fill the vacated bits with zeros.
- R5: Operation code 7 rotates opa left by shamt positions and code 8 rotates it right by shamt positions. Bits leaving one end re-enter at the other end.
- R6: For operation codes 5 to 8, a shamt of 0 returns opa unchanged.
- R7: Operation code 6 with shamt 1 gives floor(opa / 2), the unsigned halving used for signal-processing scaling.
- R8: For every operation code, flag_sign equals bit 15 of result.
- R9: For every operation code, flag_zero is 1 exactly when all 16 bits of result are 0.
- R10: No carry is reported. An add or multiply that overflows keeps only the low 16 bits, so 0x8000 + 0x8000 gives result 0 with flag_zero 1 and flag_sign 0.
- R11: Operation codes 9 to 15 give result 0, which makes flag_zero 1 and flag_sign 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand; the value shifted or rotated by the shift operations |
| opb | input | 16 | Second operand for add, multiply and logic operations |
| op | input | 4 | Operation code (0 add, 1 multiply, 2 AND, 3 OR, 4 XOR, 5 shift left, 6 shift right, 7 rotate left, 8 rotate right) |
| shamt | input | 4 | Shift or rotate distance, 0 to 15 |
| result | output | 16 | Operation result |
| flag_sign | output | 1 | Bit 15 of the result |
| flag_zero | output | 1 | Set when the result is all zeros |

## Verification
Two effects can arise from a single operation: the silent loss of the carry or of the upper product bits, and the zero detection on the truncated result. The bench provokes both at once with operands such as 0x8000 + 0x8000, 0xFFFF + 0x0001 and 0x0100 * 0x0100. Each of these overflows to exactly zero, so the result must be 0 and the flags must be zero set and sign clear, with no trace of the lost bits. Rotates at distance 0, 1 and 15 are judged in the same way. Wrap-around and the flags must both be correct on one result, because any leakage of the vacated bits would change the popcount or the sign.

// File: rtl/alu16_pkg.sv
package alu16_pkg;

    parameter int DATA_W = 16;
    parameter int SECT_W = 4;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_MUL = 4'd1,
        OP_AND = 4'd2,
        OP_OR  = 4'd3,
        OP_XOR = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8
    } alu_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic sign;
        logic zero;
    } alu_flags_t;

    typedef struct packed {
        logic go_left;
        logic wrap;
    } shift_ctl_t;

    function automatic alu_flags_t flags_of(input logic [DATA_W-1:0] r);
        alu_flags_t f;
        f.sign = r[DATA_W-1];
        f.zero = (r == '0);
        return f;
    endfunction

    function automatic logic_sel_e logic_sel_of(input alu_op_e o);
        case (o)
            OP_OR:   return LG_OR;
            OP_XOR:  return LG_XOR;
            default: return LG_AND;
        endcase
    endfunction

    function automatic shift_ctl_t shift_ctl_of(input alu_op_e o);
        shift_ctl_t c;
        c.go_left = (o == OP_SHL) || (o == OP_ROL);
        c.wrap    = (o == OP_ROL) || (o == OP_ROR);
        return c;
    endfunction

endpackage

// File: rtl/alu16_csa.sv
module alu16_csa #(
    parameter int W    = 16,
    parameter int SECT = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum
);
    localparam int NSEC = W / SECT;

    logic [NSEC-1:0] cy;
    assign cy[0] = 1'b0;

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        logic [SECT-1:0] as_w;
        logic [SECT-1:0] bs_w;
        assign as_w = a[s*SECT +: SECT];
        assign bs_w = b[s*SECT +: SECT];

        if (s == NSEC - 1) begin : g_last
            logic [SECT-1:0] r0;
            logic [SECT-1:0] r1;
            assign r0 = as_w + bs_w;
            assign r1 = as_w + bs_w + {{(SECT-1){1'b0}}, 1'b1};
            assign sum[s*SECT +: SECT] = cy[s] ? r1 : r0;
        end else begin : g_mid
            logic [SECT:0] r0;
            logic [SECT:0] r1;
            assign r0 = {1'b0, as_w} + {1'b0, bs_w};
            assign r1 = {1'b0, as_w} + {1'b0, bs_w} + {{SECT{1'b0}}, 1'b1};
            assign sum[s*SECT +: SECT] = cy[s] ? r1[SECT-1:0] : r0[SECT-1:0];
            assign cy[s+1] = cy[s] ? r1[SECT] : r0[SECT];
        end
    end

    always_comb begin
        AST_ADD_MODULO: assert (sum == a + b) else $error("carry-select sum mismatch"); // R1
    end

endmodule

// File: rtl/alu16_mul.sv
module alu16_mul #(
    parameter int W    = 16,
    parameter int SECT = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] prod
);
    logic [W-1:0][W-1:0] pp;
    logic [W-1:1][W-1:0] sr;
    logic [W-1:1][W-1:0] cr;

    for (genvar i = 0; i < W; i++) begin : g_pp
        assign pp[i] = b[i] ? (a << i) : '0;
    end

    assign sr[1] = pp[0];
    assign cr[1] = pp[1];

    for (genvar i = 2; i < W; i++) begin : g_row
        assign sr[i] = sr[i-1] ^ cr[i-1] ^ pp[i];
        assign cr[i] = ((sr[i-1] & cr[i-1]) | (sr[i-1] & pp[i]) | (cr[i-1] & pp[i])) << 1;
    end

    alu16_csa #(.W(W), .SECT(SECT)) u_final (
        .a   (sr[W-1]),
        .b   (cr[W-1]),
        .sum (prod)
    );

    always_comb begin
        AST_MUL_LOW: assert (prod == a * b) else $error("truncated product mismatch"); // R2
    end

endmodule

// File: rtl/alu16_logic.sv
module alu16_logic
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    always_comb begin
        case (sel)
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = a & b;
        endcase
    end

    always_comb begin
        if (sel == LG_XOR)
            AST_XOR_FORM: assert (y == ((a | b) & ~(a & b))) else $error("xor mismatch"); // R3
    end

endmodule

// File: rtl/alu16_shift.sv
module alu16_shift
    import alu16_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] amt,
    input  shift_ctl_t           ctl,
    output logic [W-1:0]         dout
);
    localparam int LOG = $clog2(W);

    logic [LOG:0][W-1:0] st;
    assign st[0] = din;

    for (genvar k = 0; k < LOG; k++) begin : g_stage
        localparam int D = 1 << k;
        logic [W-1:0] moved;
        always_comb begin
            if (ctl.go_left)
                moved = (st[k] << D) | (ctl.wrap ? (st[k] >> (W - D)) : '0);
            else
                moved = (st[k] >> D) | (ctl.wrap ? (st[k] << (W - D)) : '0);
        end
        assign st[k+1] = amt[k] ? moved : st[k];
    end

    assign dout = st[LOG];

    always_comb begin
        if (amt == '0)
            AST_ZERO_DIST: assert (dout == din) else $error("zero distance altered data"); // R6
        if (ctl.wrap)
            AST_ROT_KEEPS_ONES: assert ($countones(dout) == $countones(din)) else $error("rotate lost bits"); // R5
    end

endmodule

// File: rtl/alu16_core.sv
module alu16_core
    import alu16_pkg::*;
#(
    parameter int DATA_W = alu16_pkg::DATA_W,
    parameter int SECT_W = alu16_pkg::SECT_W
) (
    input  logic [DATA_W-1:0]         opa,
    input  logic [DATA_W-1:0]         opb,
    input  logic [3:0]                op,
    input  logic [$clog2(DATA_W)-1:0] shamt,
    output logic [DATA_W-1:0]         result,
    output logic                      flag_sign,
    output logic                      flag_zero
);
    alu_op_e      op_e;
    logic [DATA_W-1:0] add_y, mul_y, log_y, sh_y;
    alu_flags_t   fl;

    assign op_e = alu_op_e'(op);

    alu16_csa #(.W(DATA_W), .SECT(SECT_W)) u_add (
        .a   (opa),
        .b   (opb),
        .sum (add_y)
    );

    alu16_mul #(.W(DATA_W), .SECT(SECT_W)) u_mul (
        .a    (opa),
        .b    (opb),
        .prod (mul_y)
    );

    alu16_logic #(.W(DATA_W)) u_log (
        .a   (opa),
        .b   (opb),
        .sel (logic_sel_of(op_e)),
        .y   (log_y)
    );

    alu16_shift #(.W(DATA_W)) u_sh (
        .din  (opa),
        .amt  (shamt),
        .ctl  (shift_ctl_of(op_e)),
        .dout (sh_y)
    );

    always_comb begin
        case (op_e)
            OP_ADD:                         result = add_y;
            OP_MUL:                         result = mul_y;
            OP_AND, OP_OR, OP_XOR:          result = log_y;
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: result = sh_y;
            default:                        result = '0;
        endcase
    end

    assign fl        = flags_of(result);
    assign flag_sign = fl.sign;
    assign flag_zero = fl.zero;

    always_comb begin
        AST_FLAGS_EXCL: assert (!(flag_sign && flag_zero)) else $error("sign and zero both set"); // R9
    end

endmodule

// File: tb/tb_alu16_core.sv
module tb_alu16_core;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] opa = '0;
    logic [15:0] opb = '0;
    logic [3:0]  op = 4'd0;
    logic [3:0]  shamt = 4'd0;
    logic [15:0] result;
    logic        flag_sign;
    logic        flag_zero;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [15:0] res;
        logic        s;
        logic        z;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #10 clk = ~clk;

    alu16_core dut (
        .opa(opa), .opb(opb), .op(op), .shamt(shamt),
        .result(result), .flag_sign(flag_sign), .flag_zero(flag_zero)
    );

    function automatic logic [15:0] model(input logic [3:0] o, input logic [15:0] a,
                                          input logic [15:0] b, input logic [3:0] n);
        logic [31:0] p;
        case (o)
            4'd0: return a + b;
            4'd1: begin p = {16'd0, a} * {16'd0, b}; return p[15:0]; end
            4'd2: return a & b;
            4'd3: return a | b;
            4'd4: return a ^ b;
            4'd5: return a << n;
            4'd6: return a >> n;
            4'd7: return (n == 0) ? a : ((a << n) | (a >> (16 - n)));
            4'd8: return (n == 0) ? a : ((a >> n) | (a << (16 - n)));
            default: return 16'd0;
        endcase
    endfunction

    task automatic send(input logic [3:0] o, input logic [15:0] a, input logic [15:0] b,
                        input logic [3:0] n, input string req);
        exp_t e;
        @(posedge clk);
        #2;
        op = o; opa = a; opb = b; shamt = n;
        e.res = model(o, a, b, n);
        e.s   = e.res[15];
        e.z   = (e.res == 16'd0);
        e.req = req;
        sb.push_back(e);
    endtask

    always @(negedge clk) begin
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_checks++;
            if (result !== e.res || flag_sign !== e.s || flag_zero !== e.z) begin
                n_errors++;
                $display("FAIL %s: got res=%h s=%b z=%b expected res=%h s=%b z=%b",
                         e.req, result, flag_sign, flag_zero, e.res, e.s, e.z);
            end
        end
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // reset state: all inputs zero, add of zeros gives zero flag (R9)
        send(4'd0, 16'h0000, 16'h0000, 4'd0, "R9 reset");
        repeat (2) @(posedge clk);
        rst = 1'b0;
        // R1 add patterns
        send(4'd0, 16'h1234, 16'h4321, 4'd0, "R1 add");
        send(4'd0, 16'h000F, 16'h0001, 4'd0, "R1 add section carry");
        send(4'd0, 16'h0FFF, 16'h0001, 4'd0, "R1 add carry through sections");
        send(4'd0, 16'h7FFF, 16'h0001, 4'd0, "R8 add to negative");
        // R10 overflow to zero, carry discarded
        send(4'd0, 16'h8000, 16'h8000, 4'd0, "R10 add overflow");
        send(4'd0, 16'hFFFF, 16'h0001, 4'd0, "R10 add wrap");
        // R2 multiply
        send(4'd1, 16'h0012, 16'h0034, 4'd0, "R2 mul");
        send(4'd1, 16'hFFFF, 16'hFFFF, 4'd0, "R2 mul all ones");
        send(4'd1, 16'h0100, 16'h0100, 4'd0, "R10 mul truncates to zero");
        send(4'd1, 16'hABCD, 16'h0000, 4'd0, "R9 mul by zero");
        // R3 logic
        send(4'd2, 16'hF0F0, 16'hFF00, 4'd0, "R3 and");
        send(4'd3, 16'hF0F0, 16'h0F00, 4'd0, "R3 or");
        send(4'd4, 16'hAAAA, 16'hAAAA, 4'd0, "R3 xor self zero");
        send(4'd4, 16'hA5A5, 16'h0FF0, 4'd0, "R3 xor");
        // R4 shifts
        send(4'd5, 16'h8001, 16'h0000, 4'd1, "R4 shl");
        send(4'd5, 16'h0001, 16'h0000, 4'd15, "R4 shl max");
        send(4'd6, 16'h8000, 16'h0000, 4'd15, "R4 shr max");
        send(4'd6, 16'hF00F, 16'h0000, 4'd4, "R4 shr zero fill");
        // R7 halving
        send(4'd6, 16'h0007, 16'h0000, 4'd1, "R7 halve odd");
        send(4'd6, 16'hFFFE, 16'h0000, 4'd1, "R7 halve");
        // R5 rotates
        send(4'd7, 16'h8001, 16'h0000, 4'd1, "R5 rol");
        send(4'd7, 16'h1234, 16'h0000, 4'd15, "R5 rol 15");
        send(4'd8, 16'h0001, 16'h0000, 4'd1, "R5 ror to sign");
        send(4'd8, 16'h1234, 16'h0000, 4'd4, "R5 ror nibble");
        // R6 zero distance
        send(4'd5, 16'hC3A5, 16'h0000, 4'd0, "R6 shl zero");
        send(4'd6, 16'hC3A5, 16'h0000, 4'd0, "R6 shr zero");
        send(4'd7, 16'hC3A5, 16'h0000, 4'd0, "R6 rol zero");
        send(4'd8, 16'hC3A5, 16'h0000, 4'd0, "R6 ror zero");
        // R11 unused codes
        for (int c = 9; c < 16; c++) begin
            send(4'(c), 16'hFFFF, 16'hFFFF, 4'd3, "R11 unused code");
        end
        // sweep of rotates for R5 and flags R8
        for (int k = 0; k < 16; k++) begin
            send(4'd7, 16'h0001, 16'h0000, 4'(k), "R8 rol sweep sign");
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule